// File: doc/BRIEF.md
# Multi-rate TDM Backplane Timeslot Counter

This block produces the bit, channel and stream timing for a serial time-division backplane whose line rate is set by a two-bit mode input. It runs from a 16.384 MHz master clock. A frame lasts 125 µs, which is 2048 master clocks. An 8 kHz frame sync restarts the frame count. For each stream the block gives a one-cycle bit strobe and an active flag. For each of two stream groups it gives the current channel number and bit index. The lower group holds streams 0 to 15 and the upper group holds streams 16 to 31.

Every active stream is shifted into a byte, most significant bit first. When a channel ends, the byte is presented together with its stream position and channel number. One mode runs the two groups at different rates at the same time. For that reason each group has its own bit-period divider, while both groups share one frame counter.

Top module: `tdm_slot_timer`

## Requirements
- R1: After reset the frame count is 0 and the mode is 2 Mb/s (code 0). In that cycle no bit strobe and no byte-valid flag is set, the channel and bit index are 0, and all 32 streams are active.
- R2: The frame count advances by one per clock and wraps after 2048 clocks. A frame sync seen at a clock edge forces the count to 0 at that edge.
- R3: Mode codes set the bit period in master clocks. Code 0 (2 Mb/s) uses 8 clocks, code 1 (4 Mb/s) uses 4 clocks, and code 2 (8 Mb/s) uses 2 clocks. A stream's strobe is high in the last clock of each bit period, which is when count mod period equals period−1.
- R4: For a group with period P, the bit index is (count/P) mod 8 and the channel is count/(8P). This gives 32, 64 or 128 channels per frame.
- R5: Active streams by mode: codes 0 and 1 activate streams 0–31, code 2 activates streams 0–15, and code 3 (mixed) activates streams 0–23.
- R6: In mixed mode (code 3) the lower group runs at 2 Mb/s (period 8) and the upper group runs at 8 Mb/s (period 2).
- R7: Bits are assembled MSB first on each strobe. When a strobe falls on bit index 7, the next cycle raises rx_valid for that stream. The completed byte appears in byte lane s of rx_byte (bits 8s+7..8s), and the group's rx_chan output carries that channel.
- R8: A new mode value is adopted only at a frame boundary, which is a frame sync or the count wrapping from 2047.
- R9: An inactive stream never raises its bit strobe or its rx_valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, active high, one clock wide |
| mode_sel | input | 2 | Requested rate mode (0:2M, 1:4M, 2:8M, 3:mixed) |
| sdi | input | 32 | Serial input bit of each stream |
| bit_stb | output | 32 | Per-stream end-of-bit strobe |
| active | output | 32 | Streams active in the current mode |
| chan_lo | output | 7 | Channel number, streams 0–15 |
| bidx_lo | output | 3 | Bit index, streams 0–15 |
| chan_hi | output | 7 | Channel number, streams 16–31 |
| bidx_hi | output | 3 | Bit index, streams 16–31 |
| rx_valid | output | 32 | Byte complete, one bit per stream |
| rx_byte | output | 256 | Completed bytes, 8 bits per stream |
| rx_chan_lo | output | 7 | Channel of completed bytes, lower group |
| rx_chan_hi | output | 7 | Channel of completed bytes, upper group |

## Verification
A wrong frame count or a mode latched at the wrong time shows up in the same clock at the ports. The active mask, the strobes and the channel and bit indices all change in that cycle, so the fault is caught on the first clock after it occurs. A corrupted shift register stays hidden until its channel ends: the bad byte appears on rx_byte up to 64 clocks later, one clock after the closing strobe. The bench therefore exercises many channel completions at each rate, with random serial data and a known MSB-first pattern. It also changes mode_sel mid-frame to show that the indices do not move until the next boundary.

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int NS         = 32,
  parameter int FRAME_CLKS = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [1:0]        mode_sel,
  input  logic [NS-1:0]     sdi,
  output logic [NS-1:0]     bit_stb,
  output logic [NS-1:0]     active,
  output logic [$clog2(FRAME_CLKS)-5:0] chan_lo,
  output logic [2:0]        bidx_lo,
  output logic [$clog2(FRAME_CLKS)-5:0] chan_hi,
  output logic [2:0]        bidx_hi,
  output logic [NS-1:0]     rx_valid,
  output logic [NS*8-1:0]   rx_byte,
  output logic [$clog2(FRAME_CLKS)-5:0] rx_chan_lo,
  output logic [$clog2(FRAME_CLKS)-5:0] rx_chan_hi
);
  localparam int CW   = $clog2(FRAME_CLKS);
  localparam int CHW  = CW - 4;
  localparam int HALF = NS / 2;
  localparam int MIX  = NS * 3 / 4;
  localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

  logic [CW-1:0] cnt;
  logic [1:0]    mode;
  logic [1:0]    sh_lo, sh_hi;
  logic          tick_lo, tick_hi;

  function automatic logic tick(input logic [CW-1:0] c, input logic [1:0] s);
    logic [CW-1:0] m;
    m = (CW'(1) << s) - CW'(1);
    return (c & m) == m;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      mode <= 2'd0;
    end else begin
      cnt <= (fsync || cnt == LAST) ? '0 : cnt + CW'(1);
      if (fsync || cnt == LAST) mode <= mode_sel;
    end

  assign sh_lo = (mode == 2'd1) ? 2'd2 : (mode == 2'd2) ? 2'd1 : 2'd3;
  assign sh_hi = (mode == 2'd1) ? 2'd2 : (mode == 2'd0) ? 2'd3 : 2'd1;

  assign tick_lo = tick(cnt, sh_lo);
  assign tick_hi = tick(cnt, sh_hi);
  assign bidx_lo = 3'(cnt >> sh_lo);
  assign bidx_hi = 3'(cnt >> sh_hi);
  assign chan_lo = CHW'(cnt >> ({1'b0, sh_lo} + 3'd3));
  assign chan_hi = CHW'(cnt >> ({1'b0, sh_hi} + 3'd3));

  always_comb
    case (mode)
      2'd2:    active = NS'((64'd1 << HALF) - 64'd1);
      2'd3:    active = NS'((64'd1 << MIX) - 64'd1);
      default: active = '1;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_chan_lo <= '0;
      rx_chan_hi <= '0;
    end else begin
      rx_chan_lo <= chan_lo;
      rx_chan_hi <= chan_hi;
    end

  for (genvar s = 0; s < NS; s++) begin : g_stream
    localparam bit LO = (s < HALF);
    logic [6:0] sr;
    logic       last_bit;
    assign bit_stb[s] = active[s] & (LO ? tick_lo : tick_hi);
    assign last_bit   = LO ? (bidx_lo == 3'd7) : (bidx_hi == 3'd7);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sr            <= '0;
        rx_valid[s]   <= 1'b0;
        rx_byte[s*8 +: 8] <= '0;
      end else begin
        rx_valid[s] <= bit_stb[s] & last_bit;
        if (bit_stb[s]) begin
          sr <= {sr[5:0], sdi[s]};
          if (last_bit) rx_byte[s*8 +: 8] <= {sr, sdi[s]};
        end
      end
  end
endmodule

module tdm_slot_timer_chk #(
  parameter int NS = 32,
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fsync,
  input logic [CW-1:0] cnt,
  input logic [NS-1:0] active,
  input logic [NS-1:0] bit_stb,
  input logic [2:0]    bidx_lo,
  input logic [NS-1:0] rx_valid
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && cnt != {CW{1'b1}}) |=> cnt == $past(cnt) + CW'(1));
  // R2
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> cnt == '0);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb[0] |=> !bit_stb[0]);
  // R7
  byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb[0] && bidx_lo == 3'd7) |=> rx_valid[0]);
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(active));
  // R9
  idle_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_valid & ~$past(active)) == '0);
endmodule

bind tdm_slot_timer tdm_slot_timer_chk #(.NS(NS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .cnt(cnt), .active(active),
  .bit_stb(bit_stb), .bidx_lo(bidx_lo), .rx_valid(rx_valid)
);

// File: tb/tb_tdm_slot_timer.sv
module tb_tdm_slot_timer;
  logic clk = 0, rst_n = 0, fsync = 0;
  logic [1:0] mode_sel = 0;
  logic [31:0] sdi = 0;
  logic [31:0] bit_stb, active, rx_valid;
  logic [6:0] chan_lo, chan_hi, rx_chan_lo, rx_chan_hi;
  logic [2:0] bidx_lo, bidx_hi;
  logic [255:0] rx_byte;

  int checks = 0, failures = 0;
  bit directed = 0;

  tdm_slot_timer dut (.*);

  always #2 clk = ~clk;

  int m_cnt, m_mode;
  logic [6:0] m_sr [32];
  logic [31:0] m_rxv;
  logic [7:0] m_rxb [32];
  logic [6:0] m_rcl, m_rch;

  function automatic int shv(int md, bit hi);
    case (md)
      0: return 3;
      1: return 2;
      2: return 1;
      default: return hi ? 1 : 3;
    endcase
  endfunction

  function automatic logic [31:0] amask(int md);
    return md == 2 ? 32'h0000_FFFF : md == 3 ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit e_stb(int s);
    int p = 1 << shv(m_mode, s >= 16);
    return amask(m_mode)[s] && (m_cnt % p) == p - 1;
  endfunction

  function automatic int e_bidx(bit hi);
    return (m_cnt >> shv(m_mode, hi)) % 8;
  endfunction

  function automatic int e_chan(bit hi);
    return m_cnt >> (shv(m_mode, hi) + 3);
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h cnt=%0d mode=%0d", req, act, exp, m_cnt, m_mode);
    end
  endtask

  task automatic check_all();
    logic [31:0] es;
    logic [255:0] eb;
    for (int s = 0; s < 32; s++) es[s] = e_stb(s);
    for (int s = 0; s < 32; s++) eb[s*8 +: 8] = m_rxb[s];
    chk("R3/R6/R9 bit_stb", bit_stb, es);
    chk("R5 active", active, amask(m_mode));
    chk("R4 chan_lo", chan_lo, e_chan(0));
    chk("R4 bidx_lo", bidx_lo, e_bidx(0));
    if (m_mode != 2) begin
      chk("R6 chan_hi", chan_hi, e_chan(1));
      chk("R6 bidx_hi", bidx_hi, e_bidx(1));
    end
    chk("R7/R9 rx_valid", rx_valid, m_rxv);
    chk("R7 rx_byte", rx_byte, eb);
    if (m_rxv[15:0] != 0) chk("R7 rx_chan_lo", rx_chan_lo, m_rcl);
    if (m_rxv[31:16] != 0) chk("R7 rx_chan_hi", rx_chan_hi, m_rch);
    if (directed && m_rxv[0]) chk("R7 MSB-first pattern", rx_byte[7:0], 8'hA5);
  endtask

  task automatic advance();
    logic [31:0] nv;
    for (int s = 0; s < 32; s++) begin
      bit st = e_stb(s);
      bit l7 = e_bidx(s >= 16) == 7;
      nv[s] = st && l7;
      if (st && l7) m_rxb[s] = {m_sr[s], sdi[s]};
      if (st) m_sr[s] = {m_sr[s][5:0], sdi[s]};
    end
    m_rxv = nv;
    m_rcl = 7'(e_chan(0));
    m_rch = 7'(e_chan(1));
    if (fsync || m_cnt == 2047) begin
      m_cnt = 0;
      m_mode = mode_sel;
    end else m_cnt++;
  endtask

  task automatic step(bit fs, logic [1:0] ms, logic [31:0] d);
    @(negedge clk);
    check_all();
    fsync = fs; mode_sel = ms; sdi = d;
    advance();
  endtask

  initial begin
    m_cnt = 0; m_mode = 0; m_rxv = 0; m_rcl = 0; m_rch = 0;
    for (int s = 0; s < 32; s++) begin m_sr[s] = 0; m_rxb[s] = 0; end
    void'($urandom(32'd1234));
    #9 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 reset bit_stb", bit_stb, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset chan_lo", chan_lo, 0);
    chk("R1 reset active", active, 32'hFFFF_FFFF);
    // Directed R7: 0xA5 MSB first on every stream at 2 Mb/s
    step(1, 0, 0);
    directed = 1;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] pat = 8'hA5;
      step(0, 0, {32{pat[7 - ((m_cnt >> 3) % 8)]}});
    end
    directed = 0;
    // R8: mode request mid-frame, no sync; R2: natural wrap
    for (int i = 0; i < 2100; i++) step(0, 2'd2, $urandom);
    // Random frames with varied modes and occasional early syncs
    for (int f = 0; f < 16; f++) begin
      logic [1:0] md = 2'($urandom_range(0, 3));
      int len = ($urandom_range(0, 3) == 0) ? $urandom_range(100, 2000) : 2048;
      for (int i = 0; i < len; i++) begin
        logic [1:0] ms = (i == len / 2) ? 2'($urandom_range(0, 3)) : md;
        step((i == len - 1), ms, $urandom);
      end
      for (int i = 0; i < 3; i++) step(0, md, $urandom);
    end
    // Each mode in turn
    for (int md = 0; md < 4; md++) begin
      step(1, 2'(md), 0);
      for (int i = 0; i < 600; i++) step(0, 2'(md), $urandom);
    end
    @(negedge clk);
    check_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule